// File: doc/BRIEF.md
# Serial-to-Parallel LED Shift Driver

This block feeds a chain of up to three external 8-bit serial-in, parallel-out shift registers, the kind that sit next to front-panel LEDs. It drives three wires: a serial clock, a serial data line and a store strobe that moves the shifted word onto the parallel outputs. Software programs it through a small 32-bit register interface and writes a 24-bit output image into a data register.

A frame goes out when software asks for one, or at a fixed rate when a periodic timer is enabled. The frame length follows the highest enabled 8-bit group. Selected bits in the low byte can be taken from hardware status inputs instead of from the software image: two bits from a DSL modem, and two bits from each of two Ethernet PHYs. If a request arrives while a frame is on the wire, it is held. It then starts exactly one further frame when the current one has finished.

Top module: `led_shift_ctrl`

## Requirements
- R1: Register offsets are 0x00 control A, 0x04 control B, 0x08 output image (bits [23:0]), 0x0C spare data word, 0x10 status. After reset, control A reads 0x8000_0000 and every other register reads 0. The spare data word reads back all 32 bits written to it. An address outside the map reads 0.
- R2: Writing control A with bit 31 set requests a frame. A frame puts the frame bits on the data line most significant bit first, with exactly one active clock edge per bit. After the last bit it raises the store strobe for exactly one cycle.
- R3: The frame length is 8, 16 or 24 bits, set by the highest set bit of the group mask in control B bits [2:0]. With a mask of 0 a request is dropped: there is no clock edge and no strobe.
- R4: When control A bit 26 is 1, the serial clock idles high and the active edge is falling. When it is 0, the clock idles low and the active edge is rising.
- R5: Control A bits [25:24] hand frame bits [1:0] to the DSL status input. Control A bits [28:27] hand frame bits [3:2] to PHY A status bits [1:0]. Control B bits [16:15] hand frame bits [6:5] to PHY B status bits [1:0]. The image bit at a handed-over position is ignored. Every other frame bit comes from image bit [i].
- R6: While control B bit 31 is 1, a frame starts every CLK_HZ/f clock cycles. The rate field in control B bits [24:23] selects f: 0 gives 2 Hz, 1 gives 4 Hz, 2 gives 8 Hz and 3 gives 10 Hz. While control B bit 31 is 0, no frame starts on its own.
- R7: Any number of requests made while a frame is in progress result in exactly one further frame after the current one.
- R8: Status register bit 0 reads 1 from the cycle after a request is accepted through the store-strobe cycle, and reads 0 otherwise.
- R9: The data line is 0 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dsl_status | input | 2 | DSL modem status bits |
| phy_a_status | input | 2 | PHY A status bits |
| phy_b_status | input | 2 | PHY B status bits |
| ser_clk | output | 1 | Serial clock to the register chain |
| ser_data | output | 1 | Serial data to the register chain |
| store_strobe | output | 1 | One-cycle latch pulse after each frame |

## Verification
The hardest situations to reach from the ports are a request that lands while a frame is already shifting, and the periodic spacing. The bench reaches the first by issuing several control writes back to back just after a trigger. It then counts strobes to confirm that exactly two frames result. For the periodic spacing, the bench sets a small clock frequency parameter so that every rate produces short intervals. It then measures the cycle gap between consecutive strobes once the timer has settled. An exhaustive sweep over all 64 combinations of the three hand-over fields, run with a full 24-bit chain, shows that each handed-over bit follows its status input and ignores the image.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;

    localparam int GRP_W     = 8;
    localparam int NUM_GRP   = 3;
    localparam int FRAME_MAX = GRP_W * NUM_GRP;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int HW_W      = 8;

    localparam int ADR_CTRL_A = 'h00;
    localparam int ADR_CTRL_B = 'h04;
    localparam int ADR_IMAGE  = 'h08;
    localparam int ADR_SPARE  = 'h0C;
    localparam int ADR_STATUS = 'h10;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_STORE
    } sh_state_e;

    typedef struct packed {
        logic [1:0] dsl_en;
        logic [1:0] phya_en;
        logic [1:0] phyb_en;
        logic       fall;
        logic [2:0] groups;
        logic       tmr_en;
        logic [1:0] rate;
    } cfg_t;

    function automatic logic [LEN_W-1:0] frame_len_of(input logic [2:0] groups);
        if (groups[2])      return LEN_W'(3 * GRP_W);
        else if (groups[1]) return LEN_W'(2 * GRP_W);
        else if (groups[0]) return LEN_W'(GRP_W);
        else                return '0;
    endfunction

    function automatic int rate_hz(input logic [1:0] rate);
        case (rate)
            2'd0:    return 2;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [HW_W-1:0] hw_owned(input cfg_t c);
        return {1'b0, c.phyb_en, 1'b0, c.phya_en, c.dsl_en};
    endfunction

endpackage

// File: rtl/led_shift_regs.sv
module led_shift_regs
    import led_shift_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic                 busy,
    output logic [31:0]          rdata,
    output cfg_t                 cfg,
    output logic [FRAME_MAX-1:0] image,
    output logic                 sw_req
);
    localparam logic [ADDR_W-1:0] A_CA = ADDR_W'(ADR_CTRL_A);
    localparam logic [ADDR_W-1:0] A_CB = ADDR_W'(ADR_CTRL_B);
    localparam logic [ADDR_W-1:0] A_IM = ADDR_W'(ADR_IMAGE);
    localparam logic [ADDR_W-1:0] A_SP = ADDR_W'(ADR_SPARE);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADR_STATUS);

    logic                 a_swu;
    logic [1:0]           a_phya;
    logic                 a_fall;
    logic [1:0]           a_dsl;
    logic [1:0]           b_src;
    logic [1:0]           b_rate;
    logic [1:0]           b_phyb;
    logic [2:0]           b_grp;
    logic [FRAME_MAX-1:0] img_q;
    logic [31:0]          spare_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_swu   <= 1'b1;
            a_phya  <= '0;
            a_fall  <= 1'b0;
            a_dsl   <= '0;
            b_src   <= '0;
            b_rate  <= '0;
            b_phyb  <= '0;
            b_grp   <= '0;
            img_q   <= '0;
            spare_q <= '0;
            sw_req  <= 1'b0;
        end else begin
            sw_req <= wr && (addr == A_CA) && wdata[31];
            if (wr) begin
                case (addr)
                    A_CA: begin
                        a_swu  <= wdata[31];
                        a_phya <= wdata[28:27];
                        a_fall <= wdata[26];
                        a_dsl  <= wdata[25:24];
                    end
                    A_CB: begin
                        b_src  <= wdata[31:30];
                        b_rate <= wdata[24:23];
                        b_phyb <= wdata[16:15];
                        b_grp  <= wdata[2:0];
                    end
                    A_IM: img_q   <= wdata[FRAME_MAX-1:0];
                    A_SP: spare_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CA: begin
                rdata[31]    = a_swu;
                rdata[28:27] = a_phya;
                rdata[26]    = a_fall;
                rdata[25:24] = a_dsl;
            end
            A_CB: begin
                rdata[31:30] = b_src;
                rdata[24:23] = b_rate;
                rdata[16:15] = b_phyb;
                rdata[2:0]   = b_grp;
            end
            A_IM:    rdata[FRAME_MAX-1:0] = img_q;
            A_SP:    rdata = spare_q;
            A_ST:    rdata[0] = busy;
            default: rdata = '0;
        endcase
    end

    always_comb begin
        cfg.dsl_en  = a_dsl;
        cfg.phya_en = a_phya;
        cfg.phyb_en = b_phyb;
        cfg.fall    = a_fall;
        cfg.groups  = b_grp;
        cfg.tmr_en  = b_src[1];
        cfg.rate    = b_rate;
    end

    assign image = img_q;

endmodule

// File: rtl/led_shift_timer.sv
module led_shift_timer
    import led_shift_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int CNT_W = $clog2(CLK_HZ / 2 + 1) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;

    always_comb begin
        period = CNT_W'(CLK_HZ / rate_hz(rate));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= period - CNT_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/led_shift_mux.sv
module led_shift_mux
    import led_shift_pkg::*;
(
    input  cfg_t                 cfg,
    input  logic [FRAME_MAX-1:0] image,
    input  logic [1:0]           dsl,
    input  logic [1:0]           phya,
    input  logic [1:0]           phyb,
    output logic [FRAME_MAX-1:0] frame_bits,
    output logic [LEN_W-1:0]     frame_len
);
    logic [HW_W-1:0] owned;
    logic [HW_W-1:0] hw_val;

    assign owned  = hw_owned(cfg);
    assign hw_val = {1'b0, phyb, 1'b0, phya, dsl};

    for (genvar i = 0; i < FRAME_MAX; i++) begin : g_bit
        if (i < HW_W) begin : g_low
            assign frame_bits[i] = owned[i] ? hw_val[i] : image[i];
        end else begin : g_high
            assign frame_bits[i] = image[i];
        end
    end

    assign frame_len = frame_len_of(cfg.groups);

endmodule

// File: rtl/led_shift_serializer.sv
module led_shift_serializer
    import led_shift_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 fall_cfg,
    input  logic [FRAME_MAX-1:0] frame_bits,
    input  logic [LEN_W-1:0]     frame_len,
    output logic                 sclk,
    output logic                 sdata,
    output logic                 strobe,
    output logic                 busy
);
    localparam int HALF_W = $clog2(SCLK_HALF + 1);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCLK_HALF - 1);

    sh_state_e            state;
    logic [FRAME_MAX-1:0] bits_q;
    logic [LEN_W-1:0]     idx;
    logic [HALF_W-1:0]    hcnt;
    logic                 phase;
    logic                 fall_q;
    logic                 pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            bits_q <= '0;
            idx    <= '0;
            hcnt   <= '0;
            phase  <= 1'b0;
            fall_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            case (state)
                SH_IDLE: begin
                    fall_q <= fall_cfg;
                    if (req || pend) begin
                        pend <= 1'b0;
                        if (frame_len != '0) begin
                            bits_q <= frame_bits;
                            idx    <= frame_len - LEN_W'(1);
                            hcnt   <= '0;
                            phase  <= 1'b0;
                            state  <= SH_SHIFT;
                        end
                    end
                end
                SH_SHIFT: begin
                    if (req) pend <= 1'b1;
                    if (hcnt == HALF_LAST) begin
                        hcnt <= '0;
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (idx == '0) state <= SH_STORE;
                            else           idx   <= idx - LEN_W'(1);
                        end
                    end else begin
                        hcnt <= hcnt + HALF_W'(1);
                    end
                end
                SH_STORE: begin
                    if (req) pend <= 1'b1;
                    state <= SH_IDLE;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign busy   = (state != SH_IDLE);
    assign strobe = (state == SH_STORE);
    assign sclk   = fall_q ^ ((state == SH_SHIFT) && phase);
    assign sdata  = (state == SH_SHIFT) ? bits_q[idx] : 1'b0;

endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
    import led_shift_pkg::*;
#(
    parameter int CLK_HZ    = 125_000_000,
    parameter int SCLK_HALF = 4,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        dsl_status,
    input  logic [1:0]        phy_a_status,
    input  logic [1:0]        phy_b_status,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              store_strobe
);
    cfg_t                 cfg;
    logic [FRAME_MAX-1:0] image;
    logic [FRAME_MAX-1:0] frame_bits;
    logic [LEN_W-1:0]     frame_len;
    logic                 sw_req;
    logic                 tmr_tick;
    logic                 busy;

    led_shift_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .busy(busy), .rdata(bus_rdata), .cfg(cfg), .image(image), .sw_req(sw_req)
    );

    led_shift_timer #(.CLK_HZ(CLK_HZ)) timer_i (
        .clk(clk), .rst(rst), .en(cfg.tmr_en), .rate(cfg.rate), .tick(tmr_tick)
    );

    led_shift_mux mux_i (
        .cfg(cfg), .image(image), .dsl(dsl_status), .phya(phy_a_status),
        .phyb(phy_b_status), .frame_bits(frame_bits), .frame_len(frame_len)
    );

    led_shift_serializer #(.SCLK_HALF(SCLK_HALF)) ser_i (
        .clk(clk), .rst(rst), .req(sw_req || tmr_tick), .fall_cfg(cfg.fall),
        .frame_bits(frame_bits), .frame_len(frame_len), .sclk(ser_clk),
        .sdata(ser_data), .strobe(store_strobe), .busy(busy)
    );

endmodule

// File: rtl/led_shift_ctrl_chk.sv
module led_shift_ctrl_chk
    import led_shift_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              store,
    input logic              sdata,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [LEN_W-1:0]  frame_len
);
    p_store_once_r2: assert property (@(posedge clk) disable iff (rst)
        store |=> !store);

    p_store_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        store |-> busy);

    p_store_ends_frame_r8: assert property (@(posedge clk) disable iff (rst)
        store |=> !busy);

    p_status_read_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(ADR_STATUS)) |-> (rdata == {31'b0, busy}));

    p_data_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sdata);

    p_empty_stays_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && frame_len == '0) |=> !busy);

endmodule

bind led_shift_ctrl led_shift_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .store(store_strobe), .sdata(ser_data),
    .addr(bus_addr), .rdata(bus_rdata), .frame_len(frame_len)
);

// File: tb/led_shift_ctrl_tb_top.sv
module led_shift_ctrl_tb_top;
    localparam int CLK_HZ = 4000;
    localparam int HALF   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dsl_status = '0;
    logic [1:0]  phy_a_status = '0;
    logic [1:0]  phy_b_status = '0;
    logic        ser_clk, ser_data, store_strobe;

    always #4 clk = ~clk;

    led_shift_ctrl #(.CLK_HZ(CLK_HZ), .SCLK_HALF(HALF), .ADDR_W(5)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dsl_status(dsl_status),
        .phy_a_status(phy_a_status), .phy_b_status(phy_b_status),
        .ser_clk(ser_clk), .ser_data(ser_data), .store_strobe(store_strobe)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // serial monitor
    bit          tb_fall = 0;
    logic        prev_clk = 1'b0;
    logic [23:0] col_val = '0;
    int          col_n = 0;
    logic [23:0] last_val = '0;
    int          last_n = 0;
    int          strobe_cnt = 0;
    int          strobe_wide = 0;
    logic        prev_strobe = 1'b0;
    int          cyc = 0;
    int          last_t = 0;
    int          prev_t = 0;
    int          idle_data_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ser_clk !== prev_clk && ser_clk !== tb_fall) begin
                col_val = {col_val[22:0], ser_data};
                col_n++;
            end
            if (store_strobe) begin
                if (prev_strobe) strobe_wide++;
                last_val = col_val;
                last_n   = col_n;
                col_val  = '0;
                col_n    = 0;
                strobe_cnt++;
                prev_t = last_t;
                last_t = cyc;
            end
            prev_strobe = store_strobe;
        end
        prev_clk = ser_clk;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_strobes(input int n, input int limit);
        int target = strobe_cnt + n;
        for (int i = 0; i < limit && strobe_cnt < target; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [23:0] expect_frame(input logic [23:0] img,
            input logic [1:0] de, input logic [1:0] ae, input logic [1:0] be,
            input logic [1:0] d, input logic [1:0] a, input logic [1:0] b);
        logic [7:0] own = {1'b0, be, 1'b0, ae, de};
        logic [7:0] hw  = {1'b0, b, 1'b0, a, d};
        logic [23:0] r = img;
        r[7:0] = (img[7:0] & ~own) | (hw & own);
        return r;
    endfunction

    function automatic int len_of(input int g);
        return (g & 4) != 0 ? 24 : (g & 2) != 0 ? 16 : (g & 1) != 0 ? 8 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [23:0] img, exp_v;
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        bus_read(5'h00, rd); check(rd == 32'h8000_0000, "R1 ctrl A reset", rd, 32'h8000_0000);
        bus_read(5'h04, rd); check(rd == 0, "R1 ctrl B reset", rd, 0);
        bus_read(5'h08, rd); check(rd == 0, "R1 image reset", rd, 0);
        bus_read(5'h0C, rd); check(rd == 0, "R1 spare reset", rd, 0);
        bus_read(5'h10, rd); check(rd == 0, "R1 status reset", rd, 0);
        check(store_strobe == 0 && ser_data == 0, "R9 outputs at reset", {store_strobe, ser_data}, 0);
        bus_write(5'h0C, 32'hA5C3_1E7B);
        bus_read(5'h0C, rd); check(rd == 32'hA5C3_1E7B, "R1 spare readback", rd, 32'hA5C3_1E7B);
        bus_read(5'h14, rd); check(rd == 0, "R1 unmapped read", rd, 0);

        // R2 R3 R4 R8: group masks x both edges
        for (int e = 0; e < 2; e++) begin
            for (int g = 1; g < 8; g++) begin
                img = 24'((g * 24'h35B1C7) ^ (e * 24'hF0F0F));
                tb_fall = (e == 1);
                bus_write(5'h08, 32'(img));
                bus_write(5'h04, 32'(g));
                n0 = strobe_cnt;
                bus_write(5'h00, 32'h8000_0000 | (32'(e) << 26));
                bus_read(5'h10, rd);
                check(rd == 1, "R8 busy during frame", rd, 1);
                wait_strobes(1, 500);
                check(strobe_cnt == n0 + 1, "R2 one strobe per request", strobe_cnt - n0, 1);
                check(last_n == len_of(g), "R3 frame length", last_n, len_of(g));
                exp_v = img & 24'((1 << len_of(g)) - 1);
                check((last_val & 24'((1 << len_of(g)) - 1)) == exp_v,
                      e ? "R4 falling edge frame" : "R2 rising edge frame", last_val, exp_v);
                check(ser_clk == tb_fall, "R4 idle clock level", ser_clk, tb_fall);
                bus_read(5'h10, rd);
                check(rd == 0, "R8 idle after strobe", rd, 0);
                check(ser_data == 0, "R9 data low idle", ser_data, 0);
            end
        end
        tb_fall = 0;
        bus_write(5'h00, 32'h0);

        // R3 empty group mask
        bus_write(5'h04, 32'h0);
        n0 = strobe_cnt;
        bus_write(5'h00, 32'h8000_0000);
        repeat (100) @(negedge clk);
        check(strobe_cnt == n0 && col_n == 0, "R3 empty mask dropped", strobe_cnt - n0 + col_n, 0);

        // R5 exhaustive hand-over sweep
        for (int c = 0; c < 64; c++) begin
            logic [1:0] de, ae, be;
            de = c[1:0]; ae = c[3:2]; be = c[5:4];
            dsl_status   = 2'(c * 3 + 1);
            phy_a_status = 2'(c * 5 + 2);
            phy_b_status = 2'(~c);
            img = {16'hC3A5 ^ 16'(c), 8'(c * 37)};
            bus_write(5'h08, 32'(img));
            bus_write(5'h04, 32'h7 | (32'(be) << 15));
            bus_write(5'h00, 32'h8000_0000 | (32'(ae) << 27) | (32'(de) << 24));
            wait_strobes(1, 500);
            exp_v = expect_frame(img, de, ae, be, dsl_status, phy_a_status, phy_b_status);
            check(last_n == 24 && last_val == exp_v, "R5 hardware bit sources", last_val, exp_v);
        end
        bus_write(5'h00, 32'h0);

        // R7 pending requests collapse
        bus_write(5'h04, 32'h1);
        n0 = strobe_cnt;
        bus_write(5'h00, 32'h8000_0000);
        bus_write(5'h00, 32'h8000_0000);
        bus_write(5'h00, 32'h8000_0000);
        repeat (300) @(negedge clk);
        check(strobe_cnt == n0 + 2, "R7 pending collapses to one", strobe_cnt - n0, 2);
        check(strobe_wide == 0, "R2 strobe one cycle", strobe_wide, 0);

        // R6 periodic rates
        for (int r = 0; r < 4; r++) begin
            int hz;
            hz = (r == 0) ? 2 : (r == 1) ? 4 : (r == 2) ? 8 : 10;
            bus_write(5'h04, 32'h8000_0001 | (32'(r) << 23));
            wait_strobes(3, 3 * (CLK_HZ / hz) + 500);
            check(last_t - prev_t == CLK_HZ / hz, "R6 periodic interval", last_t - prev_t, CLK_HZ / hz);
        end
        bus_write(5'h04, 32'h1);
        repeat (50) @(negedge clk);
        n0 = strobe_cnt;
        repeat (2500) @(negedge clk);
        check(strobe_cnt == n0, "R6 timer off no frames", strobe_cnt - n0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule